// File: doc/BRIEF.md
# Hierarchical Lookahead Word Adder

This block is a purely combinational adder for two 16-bit operands and a carry input. The operands are cut into four 4-bit slices. Each slice works out, for every bit position, whether that bit creates a carry (both operand bits set) or passes an incoming one along (exactly one operand bit set). From these terms and its own carry input it finds every internal carry directly, without waiting on a chain. It also reports two slice-wide signals: one saying the slice creates a carry by itself, and one saying it would pass any incoming carry straight through.

A second layer takes the four slice-wide pairs and the word carry input, and works out each slice's carry input and the word carry output using the same lookahead equations one level up. A build parameter can swap this layer for a plain chain in which each slice's carry output drives the next slice's carry input, so the two arrangements can be compared in depth and area. Either way the block also reports word-wide create and pass-through signals. These let a wider adder put this block under a third lookahead level.

Top module: `lookahead_adder`

## Requirements
- R1: With the lookahead layer selected (the default), {co, sum} equals a + b + ci as unsigned integers for every operand and carry input.
- R2: With the slice-to-slice chain selected (USE_LOOKAHEAD = 0), {co, sum} equals a + b + ci for every operand and carry input.
- R3: grp_gen is 1 exactly when a + b, with no carry input, is 65536 or more. In that case co is 1 whatever ci is.
- R4: grp_prop is 1 exactly when every bit of a differs from the same bit of b (a == ~b). In that case co equals ci.
- R5: co equals grp_gen OR (grp_prop AND ci) in both arrangements.
- R6: When a == ~b, ci = 0 gives sum = 16'hFFFF with co = 0, and ci = 1 gives sum = 16'h0000 with co = 1.
- R7: When a and b are both zero, sum equals ci in bit 0 with all other bits zero, and co, grp_gen and grp_prop are all 0.
- R8: When a and b are both 16'hFFFF, sum is 16'hFFFE with ci in bit 0, co and grp_gen are 1, and grp_prop is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| ci | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of a + b + ci |
| co | output | 1 | Carry out of bit 15 |
| grp_gen | output | 1 | The word creates a carry whatever ci is |
| grp_prop | output | 1 | The word passes ci straight through to co |

## Verification
The hard case is a carry created in one slice that has to cross slices whose pass-through signal is set. Here the slice layer and the second layer, or the chain, both settle the same carry in the same evaluation. The hardest form is the all-pass-through word (a == ~b) with ci set, where every sum bit and co depend on ci alone. The bench drives these patterns and a 16-bit sweep of one operand against structured and random partners. Two instances run side by side, one in each arrangement, and every output of both is compared with the integer sum computed in the bench.

// File: rtl/lookahead_pkg.sv
package lookahead_pkg;
  localparam int unsigned DEF_SLICE_W  = 4;
  localparam int unsigned DEF_N_SLICES = 4;

  typedef struct packed {
    logic gen;
    logic prop;
  } grp_pair_t;
endpackage

// File: rtl/cla_lookahead_unit.sv
module cla_lookahead_unit #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] gen_in,
  input  logic [W-1:0] prop_in,
  input  logic         cin,
  output logic [W-1:0] carry,
  output logic         cout,
  output logic         grp_gen,
  output logic         grp_prop
);
  // Sum-of-products lookahead: carry into position i+1 from all generators
  // at j <= i propagated by every position above j, plus cin through all.
  function automatic logic [W:0] la_carries(input logic [W-1:0] g,
                                            input logic [W-1:0] p,
                                            input logic c0);
    logic [W:0] c;
    logic       term;
    logic       acc;
    c[0] = c0;
    for (int i = 0; i < W; i++) begin
      acc = 1'b0;
      for (int j = 0; j <= i; j++) begin
        term = g[j];
        for (int k = j + 1; k <= i; k++) term = term & p[k];
        acc = acc | term;
      end
      term = c0;
      for (int k = 0; k <= i; k++) term = term & p[k];
      c[i+1] = acc | term;
    end
    return c;
  endfunction

  logic [W:0] c_live;
  logic [W:0] c_nocin;

  always_comb begin
    c_live   = la_carries(gen_in, prop_in, cin);
    c_nocin  = la_carries(gen_in, prop_in, 1'b0);
    carry    = c_live[W-1:0];
    cout     = c_live[W];
    grp_gen  = c_nocin[W];
    grp_prop = &prop_in;
  end

  always_comb begin
    assert_gen_forces_carry_R3: assert (!grp_gen || cout)
      else $error("group generate without carry out");
    assert_prop_passes_cin_R4: assert (!grp_prop || (cout == cin))
      else $error("group propagate but carry out differs from carry in");
  end
endmodule

// File: rtl/cla_slice.sv
module cla_slice #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         grp_gen,
  output logic         grp_prop
);
  logic [W-1:0] bit_gen;
  logic [W-1:0] bit_prop;
  logic [W-1:0] bit_carry;

  assign bit_gen  = a & b;
  assign bit_prop = a ^ b;

  cla_lookahead_unit #(.W(W)) la_i (
    .gen_in  (bit_gen),
    .prop_in (bit_prop),
    .cin     (cin),
    .carry   (bit_carry),
    .cout    (cout),
    .grp_gen (grp_gen),
    .grp_prop(grp_prop)
  );

  assign sum = bit_prop ^ bit_carry;

  always_comb begin
    assert_slice_total_R1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
      else $error("slice sum mismatch");
  end
endmodule

// File: rtl/lookahead_adder.sv
module lookahead_adder #(
  parameter int unsigned SLICE_W       = lookahead_pkg::DEF_SLICE_W,
  parameter int unsigned N_SLICES      = lookahead_pkg::DEF_N_SLICES,
  parameter bit          USE_LOOKAHEAD = 1'b1
) (
  input  logic [SLICE_W*N_SLICES-1:0] a,
  input  logic [SLICE_W*N_SLICES-1:0] b,
  input  logic                        ci,
  output logic [SLICE_W*N_SLICES-1:0] sum,
  output logic                        co,
  output logic                        grp_gen,
  output logic                        grp_prop
);
  import lookahead_pkg::*;
  localparam int unsigned WIDTH = SLICE_W * N_SLICES;

  grp_pair_t [N_SLICES-1:0] slice_grp;
  logic [N_SLICES-1:0]      slice_gen;
  logic [N_SLICES-1:0]      slice_prop;
  logic [N_SLICES-1:0]      slice_cin;
  logic [N_SLICES-1:0]      slice_cout;

  for (genvar s = 0; s < N_SLICES; s++) begin : g_slice
    cla_slice #(.W(SLICE_W)) slice_i (
      .a       (a[s*SLICE_W +: SLICE_W]),
      .b       (b[s*SLICE_W +: SLICE_W]),
      .cin     (slice_cin[s]),
      .sum     (sum[s*SLICE_W +: SLICE_W]),
      .cout    (slice_cout[s]),
      .grp_gen (slice_grp[s].gen),
      .grp_prop(slice_grp[s].prop)
    );
    assign slice_gen[s]  = slice_grp[s].gen;
    assign slice_prop[s] = slice_grp[s].prop;
  end

  if (USE_LOOKAHEAD) begin : g_second_level
    cla_lookahead_unit #(.W(N_SLICES)) top_la_i (
      .gen_in  (slice_gen),
      .prop_in (slice_prop),
      .cin     (ci),
      .carry   (slice_cin),
      .cout    (co),
      .grp_gen (grp_gen),
      .grp_prop(grp_prop)
    );

    for (genvar s = 0; s + 1 < N_SLICES; s++) begin : g_handoff
      always_comb begin
        assert_slice_handoff_R1: assert (slice_cout[s] == slice_cin[s+1])
          else $error("second-level carry disagrees with slice carry out");
      end
    end
    always_comb begin
      assert_last_slice_co_R1: assert (slice_cout[N_SLICES-1] == co)
        else $error("word carry disagrees with last slice");
    end
  end else begin : g_ripple
    assign slice_cin[0] = ci;
    for (genvar s = 1; s < N_SLICES; s++) begin : g_chain
      assign slice_cin[s] = slice_cout[s-1];
    end
    assign co = slice_cout[N_SLICES-1];

    always_comb begin
      grp_gen  = 1'b0;
      grp_prop = 1'b1;
      for (int s = 0; s < N_SLICES; s++) begin
        grp_gen  = slice_gen[s] | (slice_prop[s] & grp_gen);
        grp_prop = grp_prop & slice_prop[s];
      end
    end
  end

  always_comb begin
    assert_word_carry_R5: assert (co == (grp_gen | (grp_prop & ci)))
      else $error("word carry inconsistent with group terms");
    assert_word_total_R2: assert ({co, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, ci}))
      else $error("word sum mismatch");
  end
endmodule

// File: tb/lookahead_adder_tb_top.sv
`timescale 1ns/1ps
module lookahead_adder_tb_top;
  localparam int unsigned W = 16;
  localparam int unsigned MAX_CYCLES = 200000;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [W-1:0] a, b;
  logic         ci;
  logic [W-1:0] sum_la, sum_rp;
  logic         co_la, co_rp, gg_la, gg_rp, gp_la, gp_rp;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  lookahead_adder #(.USE_LOOKAHEAD(1'b1)) dut_i (
    .a(a), .b(b), .ci(ci), .sum(sum_la), .co(co_la),
    .grp_gen(gg_la), .grp_prop(gp_la)
  );

  lookahead_adder #(.USE_LOOKAHEAD(1'b0)) dut_rip_i (
    .a(a), .b(b), .ci(ci), .sum(sum_rp), .co(co_rp),
    .grp_gen(gg_rp), .grp_prop(gp_rp)
  );

  task automatic chk(input string req, input string what,
                     input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s a=%h b=%h ci=%0d actual=%h expected=%h",
               req, what, a, b, ci, act, exp);
    end
  endtask

  // Drive one vector, wait off-edge, compare both arrangements to arithmetic.
  task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv);
    logic [W:0] total;
    logic       exp_gen, exp_prop;
    a = av; b = bv; ci = cv;
    #1;
    total    = {1'b0, av} + {1'b0, bv} + {{W{1'b0}}, cv};
    exp_gen  = (({1'b0, av} + {1'b0, bv}) >= 17'h10000);
    exp_prop = ((av ^ bv) == {W{1'b1}});
    chk("R1", "lookahead {co,sum}", {co_la, sum_la}, total);
    chk("R2", "ripple {co,sum}", {co_rp, sum_rp}, total);
    chk("R3", "grp_gen both", {15'd0, gg_la, gg_rp}, {15'd0, exp_gen, exp_gen});
    chk("R4", "grp_prop both", {15'd0, gp_la, gp_rp}, {15'd0, exp_prop, exp_prop});
    chk("R5", "co from groups", {15'd0, co_la, co_rp},
        {15'd0, exp_gen | (exp_prop & cv), exp_gen | (exp_prop & cv)});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles >= MAX_CYCLES) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, MAX_CYCLES);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; ci = 1'b0;
    @(negedge clk);

    // R7: all-zero operands, both carry-in values.
    for (int c = 0; c < 2; c++) begin
      apply('0, '0, c[0]);
      chk("R7", "zero sum", {1'b0, sum_la}, {16'd0, c[0]});
      chk("R7", "zero flags", {14'd0, co_la, gg_la, gp_la}, 17'd0);
    end

    // R8: all-one operands.
    for (int c = 0; c < 2; c++) begin
      apply('1, '1, c[0]);
      chk("R8", "ones sum", {1'b0, sum_rp}, {1'b0, 15'h7FFF, c[0]});
      chk("R8", "ones flags", {14'd0, co_la, gg_la, gp_la}, 17'b110);
    end

    // R6: all-propagate operands with ci toggling.
    for (int i = 0; i < 64; i++) begin
      logic [W-1:0] x;
      x = (i == 0) ? 16'h0000 : (i == 1) ? 16'hA5A5 : W'($urandom);
      for (int c = 0; c < 2; c++) begin
        apply(x, ~x, c[0]);
        chk("R6", "prop-all lookahead", {co_la, sum_la}, c[0] ? 17'h10000 : 17'h0FFFF);
        chk("R6", "prop-all ripple", {co_rp, sum_rp}, c[0] ? 17'h10000 : 17'h0FFFF);
      end
    end

    // Full sweep of a against structured and random partners.
    for (int i = 0; i < 65536; i++) begin
      logic [W-1:0] av;
      av = W'(i);
      apply(av, W'(i * 37 + 1) ^ {av[7:0], av[15:8]}, i[0]);
      if ((i & 7) == 0) apply(av, W'($urandom), i[1]);
    end

    // Slice-boundary carries: a generate in one slice crossing propagate slices.
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 2; c++) begin
        apply(16'hFFFF >> (4 * s), 16'h0001, c[0]);
        apply(16'h8888, 16'h7777 | (16'h0001 << (4 * s)), c[0]);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule